// File: doc/BRIEF.md
# Dual-Mode Interval Countdown Timer

This block is a 16-bit down-counter with a reload latch, run from a single byte-wide control register. Software writes the reload value as a low byte and a high byte. It then starts the timer and picks one of three count sources: a system tick enable, rising edges on an external count pin, or underflow pulses from a companion timer, so two instances can be chained into a longer interval. When a count event arrives while the counter is at zero, the counter reloads from the latch and raises a one-cycle underflow request. That request serves both as the interrupt request and as the cascade source for a second instance.

Two run modes are available. In the repeating mode the timer keeps going after each reload. In the single-shot mode it clears its own start bit on the underflow. An optional port pin can show each underflow as a one-cycle pulse, or as a level that flips on every underflow. A write-only load strobe copies the latch into the counter on demand. The live count can be read back a byte at a time while the timer runs.

Top module: `itmr_top`

## Requirements
- R1: After synchronous reset the counter and the latch hold 16'hFFFF. The control byte reads 8'h00, and `underflow`, `pin_oe` and `pin_out` are 0.
- R2: A write with `wr_sel`=0 sets the latch low byte and a write with `wr_sel`=1 sets the latch high byte. A high-byte write while control bit 0 is 0 also loads {high, low} into the counter. A high-byte write while the timer runs leaves the counter alone.
- R3: While control bit 0 (start) is 1, each count event lowers the counter by one. While it is 0, the counter holds its value.
- R4: A count event that finds the counter at 0 reloads the latch value and drives `underflow` high for exactly the next cycle. A latch value N therefore gives one underflow every N+1 events.
- R5: With control bit 3 at 0 (repeating), the start bit stays 1 across underflows. With bit 3 at 1 (single-shot), the underflow clears the start bit and later events are ignored.
- R6: Writing the control byte (`wr_sel`=2) with bit 4 set copies the latch into the counter at that edge, whatever the start bit is. Bit 4 is not stored and always reads 0.
- R7: With control bit 5 at 1 and bit 6 at 0, only rising edges of `cnt_pin` are counted, after a synchronizer of SYNC_STAGES flops. `tick_en` is ignored.
- R8: With control bit 6 at 1 (CASCADE_EN=1), each cycle with `casc_in` high counts one event. This takes priority over bit 5, and `tick_en` and `cnt_pin` are ignored.
- R9: `pin_oe` equals control bit 1. While bit 1 is 0, `pin_out` is 0.
- R10: With bit 1 at 1 and bit 2 at 0, `pin_out` is high for exactly the one cycle after each `underflow` cycle. With bit 2 at 1, `pin_out` shows a level that starts at 0 after reset and flips in the cycle after each underflow that occurs while bit 2 is 1.
- R11: `rd_data` is combinational: `rd_sel`=0 gives the live counter low byte, 1 gives the live high byte, 2 gives the control byte, and 3 gives 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 latch low, 1 latch high, 2 control |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Read source: 0 count low, 1 count high, 2 control, 3 zero |
| rd_data | output | 8 | Read data |
| tick_en | input | 1 | System tick enable, one event per high cycle |
| cnt_pin | input | 1 | External count pin, asynchronous |
| casc_in | input | 1 | Underflow pulse from a companion timer |
| underflow | output | 1 | One-cycle underflow / interrupt request |
| pin_oe | output | 1 | Port pin routed to the timer |
| pin_out | output | 1 | Timer port pin value |

## Verification
The bench builds the timer with CASCADE_EN=1 and SYNC_STAGES=2. Cascade selection is therefore present: its priority over the pin source can be driven directly through `casc_in`, without a second instance. The two-flop synchronizer keeps the edge-count latency short enough that pin pulses four cycles wide count exactly once each. A table of latch values and event counts covers plain countdown, several underflows in one run, and the latch-zero case where every event underflows.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;

    // control byte bit positions (software decodes these)
    localparam int B_START  = 0;
    localparam int B_ROUTE  = 1;
    localparam int B_TOGGLE = 2;
    localparam int B_ONESHOT= 3;
    localparam int B_LOAD   = 4;
    localparam int B_EXT    = 5;
    localparam int B_CASC   = 6;

    typedef enum logic [1:0] {
        SEL_LO   = 2'd0,
        SEL_HI   = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } itmr_sel_e;

    typedef struct packed {
        logic casc;
        logic ext;
        logic oneshot;
        logic toggle;
        logic route;
        logic start;
    } itmr_ctrl_t;

    function automatic itmr_ctrl_t ctrl_from_byte(input logic [BYTE_W-1:0] d, input logic casc_ok);
        itmr_ctrl_t c;
        c.casc    = d[B_CASC] & casc_ok;
        c.ext     = d[B_EXT];
        c.oneshot = d[B_ONESHOT];
        c.toggle  = d[B_TOGGLE];
        c.route   = d[B_ROUTE];
        c.start   = d[B_START];
        return c;
    endfunction

    function automatic logic [BYTE_W-1:0] ctrl_to_byte(input itmr_ctrl_t c);
        logic [BYTE_W-1:0] b;
        b = '0;
        b[B_CASC]    = c.casc;
        b[B_EXT]     = c.ext;
        b[B_ONESHOT] = c.oneshot;
        b[B_TOGGLE]  = c.toggle;
        b[B_ROUTE]   = c.route;
        b[B_START]   = c.start;
        return b;
    endfunction
endpackage

// File: rtl/itmr_edge.sv
module itmr_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= pin_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[STAGES-2:0], pin_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[STAGES-1];
    end

    assign rise_o = sync_q[STAGES-1] & ~prev_q;

    // R7: one edge yields a single count event
    p_rise_single_r7: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);
endmodule

// File: rtl/itmr_ctrl.sv
module itmr_ctrl
    import itmr_pkg::*;
#(
    parameter bit CASCADE_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              unf_now_i,
    output itmr_ctrl_t        ctrl_o,
    output logic              force_ld_o
);
    itmr_ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_i) begin
            ctrl_q <= ctrl_from_byte(wdata_i, CASCADE_EN);
        end else if (unf_now_i && ctrl_q.oneshot) begin
            ctrl_q.start <= 1'b0;
        end
    end

    assign ctrl_o     = ctrl_q;
    assign force_ld_o = wr_i & wdata_i[B_LOAD];

    // R5: single-shot stops at underflow, repeating keeps running
    p_oneshot_stop_r5: assert property (@(posedge clk) disable iff (rst)
        (unf_now_i && ctrl_q.oneshot && !wr_i) |=> !ctrl_q.start);
    p_repeat_keep_r5: assert property (@(posedge clk) disable iff (rst)
        (unf_now_i && !ctrl_q.oneshot && !wr_i) |=> ctrl_q.start);
endmodule

// File: rtl/itmr_count.sv
module itmr_count
    import itmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              force_ld_i,
    input  logic              run_i,
    input  logic              evt_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              unf_now_o,
    output logic              unf_o
);
    logic [BYTE_W-1:0] lat_lo_q, lat_hi_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              unf_q;
    logic              ld;
    logic [CNT_W-1:0]  ld_val;

    assign ld     = force_ld_i | (wr_hi_i & ~run_i);
    assign ld_val = {(wr_hi_i ? wdata_i : lat_hi_q), lat_lo_q};
    assign unf_now_o = run_i & evt_i & ~ld & (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_lo_q <= '1;
            lat_hi_q <= '1;
        end else begin
            if (wr_lo_i) lat_lo_q <= wdata_i;
            if (wr_hi_i) lat_hi_q <= wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '1;
            unf_q <= 1'b0;
        end else begin
            unf_q <= 1'b0;
            if (ld) begin
                cnt_q <= ld_val;
            end else if (run_i && evt_i) begin
                if (cnt_q == '0) begin
                    cnt_q <= {lat_hi_q, lat_lo_q};
                    unf_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign cnt_o = cnt_q;
    assign unf_o = unf_q;

    // R4: underflow only follows a zero count
    p_unf_from_zero_r4: assert property (@(posedge clk) disable iff (rst)
        unf_q |-> ($past(cnt_q) == '0));
    // R3: a stopped timer holds its count
    p_hold_stopped_r3: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !force_ld_i && !wr_hi_i) |=> $stable(cnt_q));
endmodule

// File: rtl/itmr_outpin.sv
module itmr_outpin (
    input  logic clk,
    input  logic rst,
    input  logic unf_i,
    input  logic route_i,
    input  logic toggle_i,
    output logic pin_oe_o,
    output logic pin_out_o
);
    logic pulse_q, tog_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= 1'b0;
            tog_q   <= 1'b0;
        end else begin
            pulse_q <= unf_i;
            if (unf_i && toggle_i) tog_q <= ~tog_q;
        end
    end

    assign pin_oe_o  = route_i;
    assign pin_out_o = route_i & (toggle_i ? tog_q : pulse_q);

    // R10: toggle form flips once per underflow
    p_toggle_flip_r10: assert property (@(posedge clk) disable iff (rst)
        (unf_i && toggle_i) |=> (tog_q != $past(tog_q)));
endmodule

// File: rtl/itmr_top.sv
module itmr_top
    import itmr_pkg::*;
#(
    parameter bit CASCADE_EN  = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    input  logic [7:0] wr_data,
    input  logic [1:0] rd_sel,
    output logic [7:0] rd_data,
    input  logic       tick_en,
    input  logic       cnt_pin,
    input  logic       casc_in,
    output logic       underflow,
    output logic       pin_oe,
    output logic       pin_out
);
    itmr_ctrl_t       ctrl;
    logic             force_ld, unf_now, unf, pin_rise, evt;
    logic [CNT_W-1:0] cnt;
    logic             wr_lo, wr_hi, wr_ct;

    assign wr_lo = wr_en & (itmr_sel_e'(wr_sel) == SEL_LO);
    assign wr_hi = wr_en & (itmr_sel_e'(wr_sel) == SEL_HI);
    assign wr_ct = wr_en & (itmr_sel_e'(wr_sel) == SEL_CTRL);

    itmr_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst(rst), .pin_i(cnt_pin), .rise_o(pin_rise)
    );

    generate
        if (CASCADE_EN) begin : g_casc
            assign evt = ctrl.casc ? casc_in : (ctrl.ext ? pin_rise : tick_en);
        end else begin : g_nocasc
            logic casc_unused;
            assign casc_unused = casc_in;
            assign evt = ctrl.ext ? pin_rise : tick_en;
        end
    endgenerate

    itmr_ctrl #(.CASCADE_EN(CASCADE_EN)) u_ctrl (
        .clk(clk), .rst(rst), .wr_i(wr_ct), .wdata_i(wr_data),
        .unf_now_i(unf_now), .ctrl_o(ctrl), .force_ld_o(force_ld)
    );

    itmr_count u_count (
        .clk(clk), .rst(rst), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi),
        .wdata_i(wr_data), .force_ld_i(force_ld), .run_i(ctrl.start),
        .evt_i(evt), .cnt_o(cnt), .unf_now_o(unf_now), .unf_o(unf)
    );

    itmr_outpin u_pin (
        .clk(clk), .rst(rst), .unf_i(unf), .route_i(ctrl.route),
        .toggle_i(ctrl.toggle), .pin_oe_o(pin_oe), .pin_out_o(pin_out)
    );

    assign underflow = unf;

    always_comb begin
        unique case (itmr_sel_e'(rd_sel))
            SEL_LO:   rd_data = cnt[BYTE_W-1:0];
            SEL_HI:   rd_data = cnt[CNT_W-1:BYTE_W];
            SEL_CTRL: rd_data = ctrl_to_byte(ctrl);
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: tb/test_itmr_top.sv
module test_itmr_top;
    timeunit 1ns;
    timeprecision 100ps;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_sel = '0;
    logic [7:0] rd_data;
    logic       tick_en = 1'b0, cnt_pin = 1'b0, casc_in = 1'b0;
    logic       underflow, pin_oe, pin_out;

    int checks = 0, fails = 0;
    int unf_cnt = 0, pin_cnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    itmr_top #(.CASCADE_EN(1'b1), .SYNC_STAGES(2)) i_itmr_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .tick_en(tick_en), .cnt_pin(cnt_pin),
        .casc_in(casc_in), .underflow(underflow), .pin_oe(pin_oe), .pin_out(pin_out)
    );

    always @(negedge clk) begin
        if (underflow) unf_cnt++;
        if (pin_out)   pin_cnt++;
    end

    // latch, events, expected count, expected underflows
    localparam logic [55:0] VEC [0:4] = '{
        {16'd10,     16'd3,  16'd7,      8'd0},
        {16'd5,      16'd6,  16'd5,      8'd1},
        {16'd0,      16'd4,  16'd0,      8'd4},
        {16'h1234,   16'd53, 16'h11FF,   8'd0},
        {16'd3,      16'd9,  16'd2,      8'd2}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(negedge clk);
        end
        tick_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] s, input int exp, input string req);
        rd_sel = s;
        #0.5;
        check(req, int'(rd_data), exp);
    endtask

    task automatic rd_cnt(input int exp, input string req);
        int v;
        rd_sel = 2'd0; #0.5; v = int'(rd_data);
        rd_sel = 2'd1; #0.5; v = v | (int'(rd_data) << 8);
        check(req, v, exp);
    endtask

    task automatic set_latch(input logic [15:0] v);
        wr(2'd2, 8'h00);
        wr(2'd0, v[7:0]);
        wr(2'd1, v[15:8]);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd_cnt(16'hFFFF, "R1 count");
        rd_chk(2'd2, 8'h00, "R1 ctrl");
        check("R1 outputs", {underflow, pin_oe, pin_out}, 0);

        // vector table: R2 R3 R4 R5
        for (int k = 0; k < 5; k++) begin
            logic [15:0] lat, n, ec;
            logic [7:0]  eu;
            {lat, n, ec, eu} = VEC[k];
            set_latch(lat);
            rd_cnt(lat, "R2 stopped high write loads");
            unf_cnt = 0;
            wr(2'd2, 8'h01);
            ticks(n);
            rd_chk(2'd2, 8'h01, "R5 repeating keeps start");
            wr(2'd2, 8'h00);
            rd_cnt(ec, "R3 R4 count after events");
            check("R4 underflow count", unf_cnt, eu);
        end

        // R3 stopped timer ignores ticks
        ticks(3);
        rd_cnt(16'd2, "R3 hold while stopped");

        // R2 high write while running leaves count
        set_latch(16'd100);
        wr(2'd2, 8'h01);
        ticks(5);
        wr(2'd1, 8'h02);
        wr(2'd2, 8'h00);
        rd_cnt(16'd95, "R2 running high write");
        // R6 force load
        wr(2'd2, 8'h10);
        rd_cnt(16'h0264, "R6 force load");
        rd_chk(2'd2, 8'h00, "R6 load bit reads 0");

        // R5 single-shot
        set_latch(16'd2);
        unf_cnt = 0;
        wr(2'd2, 8'h09);
        ticks(5);
        rd_chk(2'd2, 8'h08, "R5 single-shot clears start");
        rd_cnt(16'd2, "R5 single-shot stops");
        check("R5 single-shot underflows", unf_cnt, 1);

        // R7 external pin
        set_latch(16'd10);
        wr(2'd2, 8'h21);
        ticks(4);
        rd_cnt(16'd10, "R7 ticks ignored");
        for (int p = 0; p < 3; p++) begin
            cnt_pin = 1'b1; repeat (4) @(negedge clk);
            cnt_pin = 1'b0; repeat (4) @(negedge clk);
        end
        rd_cnt(16'd7, "R7 pin edges");

        // R8 cascade priority
        set_latch(16'd10);
        wr(2'd2, 8'h61);
        tick_en = 1'b1; cnt_pin = 1'b1;
        for (int p = 0; p < 2; p++) begin
            casc_in = 1'b1; @(negedge clk);
            casc_in = 1'b0; repeat (3) @(negedge clk);
        end
        tick_en = 1'b0; cnt_pin = 1'b0;
        repeat (4) @(negedge clk);
        rd_cnt(16'd8, "R8 cascade events");

        // R9 R10 pulse form
        set_latch(16'd1);
        pin_cnt = 0;
        wr(2'd2, 8'h03);
        ticks(6);
        repeat (2) @(negedge clk);
        check("R9 pin routed", pin_oe, 1);
        check("R10 pulse count", pin_cnt, 3);
        // R10 toggle form
        wr(2'd2, 8'h07);
        ticks(6);
        repeat (2) @(negedge clk);
        check("R10 toggle after three", pin_out, 1);
        ticks(2);
        repeat (2) @(negedge clk);
        check("R10 toggle after four", pin_out, 0);
        // R9 unrouted
        wr(2'd2, 8'h05);
        pin_cnt = 0;
        ticks(4);
        repeat (2) @(negedge clk);
        check("R9 pin_oe off", pin_oe, 0);
        check("R9 pin quiet", pin_cnt, 0);

        // R11 unused read slot
        rd_chk(2'd3, 8'h00, "R11 slot 3");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule